// File: doc/BRIEF.md
# Grouped Lookahead Adder

This block is a purely combinational two-operand binary adder for an ALU datapath. The operand width is divided into equal lookahead groups. Inside each group, every bit forms a generate term (both inputs set) and a propagate term (exactly one input set). Each internal carry is then written as one flat sum-of-products of those terms and the group's incoming carry, so no in-group carry waits on its neighbour. Between groups the carry moves in series: the carry leaving one group enters the next one up.

Each group also reports a group generate and a group propagate. A later lookahead level can use these to skip the serial hop between groups. Subtraction control and status flags are not part of this block; the surrounding ALU provides them. The default build is 32 bits in four groups of 8 bits.

Top module: `cla32_adder`

## Requirements
- R1: `sum_out` equals (`a_in` + `b_in` + `carry_in`) modulo 2^DATA_W for every input combination.
- R2: `carry_out` equals bit DATA_W of the full-precision sum `a_in` + `b_in` + `carry_in`.
- R3: `grp_prop_out[k]` covers bits [8k+7:8k] by default. It is 1 exactly when every bit position in that slice has one operand bit set and the other clear.
- R4: `grp_gen_out[k]` is 1 exactly when the slice for group k, added with a zero carry-in, produces a carry out of its top bit.
- R5: The carry leaving group k equals `grp_gen_out[k]` OR (`grp_prop_out[k]` AND the carry entering group k). The carry entering group 0 is `carry_in`. The carry entering group k+1 is the carry leaving group k. The carry leaving the last group is `carry_out`.
- R6: `grp_gen_out[k]` and `grp_prop_out[k]` are never both 1.
- R7: A bit position where both operands are 0 absorbs an incoming carry. The carry does not reach the next position, and that position's sum bit is the incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | DATA_W | First addend |
| b_in | input | DATA_W | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | DATA_W | Sum modulo 2^DATA_W |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen_out | output | DATA_W/GROUP_W | Per-group generate, group 0 at bit 0 |
| grp_prop_out | output | DATA_W/GROUP_W | Per-group propagate, group 0 at bit 0 |

## Verification
Two functions can act in the same evaluation: a group's internal lookahead, and the serial hop of its carry into the next group. The bench provokes both at once in two ways. One is a carry generated low or supplied through `carry_in` that has to cross every group while each group propagates. The other is a carry that crosses one boundary and is then absorbed by killing bits. Every case is judged at the ports. Sum and carry-out are compared with a wide reference sum. The carry that crosses each group boundary is rebuilt from the sum, operand and group outputs at that boundary bit, and is checked against the group's generate/propagate relation.

// File: rtl/cla_pkg.sv
package cla_pkg;
   parameter int unsigned CLA_DATA_W  = 32;
   parameter int unsigned CLA_GROUP_W = 8;
   parameter int unsigned CLA_MAX_GROUP_W = 16;
endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] gen_o,
   output logic [W-1:0] prop_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen_o[i]  = a_i[i] & b_i[i];
      assign prop_o[i] = a_i[i] ^ b_i[i];
   end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] gen_i,
   input  logic [W-1:0] prop_i,
   input  logic         cin_i,
   output logic [W-1:0] bit_cin_o,
   output logic         cout_o,
   output logic         grp_gen_o,
   output logic         grp_prop_o
);
   logic [W:0] carry;

   // Each carry is a flat OR of product terms; no term reads another carry.
   always_comb begin
      logic term;
      logic acc;
      carry[0] = cin_i;
      for (int k = 0; k < W; k++) begin
         acc = 1'b0;
         for (int j = -1; j <= k; j++) begin
            term = (j < 0) ? cin_i : gen_i[j];
            for (int m = j + 1; m <= k; m++) begin
               term = term & prop_i[m];
            end
            acc = acc | term;
         end
         carry[k+1] = acc;
      end
   end

   always_comb begin
      logic term;
      logic acc;
      acc = 1'b0;
      for (int j = 0; j < W; j++) begin
         term = gen_i[j];
         for (int m = j + 1; m < W; m++) begin
            term = term & prop_i[m];
         end
         acc = acc | term;
      end
      grp_gen_o = acc;
   end

   assign grp_prop_o = &prop_i;
   assign bit_cin_o  = carry[W-1:0];
   assign cout_o     = carry[W];
endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] prop_i,
   input  logic [W-1:0] cin_i,
   output logic [W-1:0] sum_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i] = prop_i[i] ^ cin_i[i];
   end
endmodule

// File: rtl/cla32_adder.sv
module cla32_adder #(
   parameter int unsigned DATA_W  = cla_pkg::CLA_DATA_W,
   parameter int unsigned GROUP_W = cla_pkg::CLA_GROUP_W,
   localparam int unsigned NUM_GRP = DATA_W / GROUP_W
) (
   input  logic [DATA_W-1:0]  a_in,
   input  logic [DATA_W-1:0]  b_in,
   input  logic               carry_in,
   output logic [DATA_W-1:0]  sum_out,
   output logic               carry_out,
   output logic [NUM_GRP-1:0] grp_gen_out,
   output logic [NUM_GRP-1:0] grp_prop_out
);
   if (GROUP_W == 0 || GROUP_W > cla_pkg::CLA_MAX_GROUP_W) begin : g_bad_grp
      $error("cla32_adder: GROUP_W out of range");
   end
   if (DATA_W % GROUP_W != 0) begin : g_bad_div
      $error("cla32_adder: DATA_W must be a multiple of GROUP_W");
   end

   logic [NUM_GRP:0] grp_carry;
   assign grp_carry[0] = carry_in;

   for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
      localparam int unsigned LO = k * GROUP_W;
      logic [GROUP_W-1:0] gen_w;
      logic [GROUP_W-1:0] prop_w;
      logic [GROUP_W-1:0] bcin_w;

      cla_pg_gen #(.W(GROUP_W)) pg_i (
         .a_i   (a_in[LO +: GROUP_W]),
         .b_i   (b_in[LO +: GROUP_W]),
         .gen_o (gen_w),
         .prop_o(prop_w)
      );

      cla_group #(.W(GROUP_W)) la_i (
         .gen_i     (gen_w),
         .prop_i    (prop_w),
         .cin_i     (grp_carry[k]),
         .bit_cin_o (bcin_w),
         .cout_o    (grp_carry[k+1]),
         .grp_gen_o (grp_gen_out[k]),
         .grp_prop_o(grp_prop_out[k])
      );

      cla_sum #(.W(GROUP_W)) sum_i (
         .prop_i(prop_w),
         .cin_i (bcin_w),
         .sum_o (sum_out[LO +: GROUP_W])
      );
   end

   assign carry_out = grp_carry[NUM_GRP];
endmodule

// File: rtl/cla32_adder_chk.sv
module cla32_adder_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned GROUP_W = 8,
   localparam int unsigned NUM_GRP = DATA_W / GROUP_W
) (
   input logic [DATA_W-1:0]  a_in,
   input logic [DATA_W-1:0]  b_in,
   input logic               carry_in,
   input logic [DATA_W-1:0]  sum_out,
   input logic               carry_out,
   input logic [NUM_GRP-1:0] grp_gen_out,
   input logic [NUM_GRP-1:0] grp_prop_out
);
   logic [DATA_W:0] ref_full;
   assign ref_full = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, carry_in};

   always_comb begin
      p_sum_r1: assert (sum_out == ref_full[DATA_W-1:0])
         else $error("R1 sum mismatch");
      p_cout_r2: assert (carry_out == ref_full[DATA_W])
         else $error("R2 carry-out mismatch");
   end

   for (genvar k = 0; k < NUM_GRP; k++) begin : g_chk
      localparam int unsigned LO = k * GROUP_W;
      localparam int unsigned HI = LO + GROUP_W;
      logic cin_k;
      logic cout_k;
      assign cin_k = sum_out[LO] ^ a_in[LO] ^ b_in[LO];
      if (k == NUM_GRP - 1) begin : g_last
         assign cout_k = carry_out;
      end else begin : g_mid
         assign cout_k = sum_out[HI] ^ a_in[HI] ^ b_in[HI];
      end
      always_comb begin
         p_link_r5: assert (cout_k == (grp_gen_out[k] | (grp_prop_out[k] & cin_k)))
            else $error("R5 group carry relation broken");
         p_excl_r6: assert (!(grp_gen_out[k] && grp_prop_out[k]))
            else $error("R6 generate and propagate both set");
      end
   end
endmodule

bind cla32_adder cla32_adder_chk #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) chk_i (
   .a_in        (a_in),
   .b_in        (b_in),
   .carry_in    (carry_in),
   .sum_out     (sum_out),
   .carry_out   (carry_out),
   .grp_gen_out (grp_gen_out),
   .grp_prop_out(grp_prop_out)
);

// File: tb/cla32_adder_tb_top.sv
module cla32_adder_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned GW = 8;
   localparam int unsigned NG = DW / GW;
   localparam int NVEC = 12;

   localparam logic [DW-1:0] VEC_A [NVEC] = '{
      32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
      32'h1234_5678, 32'h0000_00FF, 32'h00FF_00FF, 32'h8000_0000,
      32'hDEAD_BEEF, 32'hA5A5_A5A5, 32'h0000_FF00, 32'h0000_0000};
   localparam logic [DW-1:0] VEC_B [NVEC] = '{
      32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001,
      32'h9ABC_DEF0, 32'h0000_0001, 32'hFF00_FF00, 32'h8000_0000,
      32'h2152_4110, 32'h5A5A_5A5A, 32'h0000_0100, 32'h0000_0000};
   localparam logic VEC_C [NVEC] = '{
      1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [DW-1:0] a, b, s;
   logic          ci, co;
   logic [NG-1:0] gg, gp;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   cla32_adder #(.DATA_W(DW), .GROUP_W(GW)) dut_i (
      .a_in(a), .b_in(b), .carry_in(ci),
      .sum_out(s), .carry_out(co),
      .grp_gen_out(gg), .grp_prop_out(gp)
   );

   task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [DW-1:0] av, input logic [DW-1:0] bv, input logic cv);
      @(negedge clk);
      a = av; b = bv; ci = cv;
      #2;
   endtask

   task automatic check_all();
      logic [DW:0] full;
      logic [GW:0] gs;
      logic [NG:0] link;
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
      chk("R1", {1'b0, s}, {1'b0, full[DW-1:0]});
      chk("R2", {{DW{1'b0}}, co}, {{DW{1'b0}}, full[DW]});
      link[0] = ci;
      for (int k = 0; k < NG; k++) begin
         gs = {1'b0, a[k*GW +: GW]} + {1'b0, b[k*GW +: GW]};
         chk("R3", {{DW{1'b0}}, gp[k]}, {{DW{1'b0}}, ((a[k*GW +: GW] ^ b[k*GW +: GW]) == '1)});
         chk("R4", {{DW{1'b0}}, gg[k]}, {{DW{1'b0}}, gs[GW]});
         chk("R6", {{DW{1'b0}}, gg[k] & gp[k]}, '0);
         link[k+1] = (k == NG - 1) ? co : (s[(k+1)*GW] ^ a[(k+1)*GW] ^ b[(k+1)*GW]);
         chk("R5", {{DW{1'b0}}, link[k+1]}, {{DW{1'b0}}, gg[k] | (gp[k] & link[k])});
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; ci = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      // reset state: zero operands give all-zero outputs (R1, R2)
      chk("R1 reset", {1'b0, s}, '0);
      chk("R2 reset", {{DW{1'b0}}, co}, '0);
      chk("R4 reset", {{(DW+1-NG){1'b0}}, gg}, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC_A[i], VEC_B[i], VEC_C[i]);
         check_all();
      end

      // R5: carry in ripples through every propagating group to carry_out
      apply(32'h00FF_00FF, 32'hFF00_FF00, 1'b1);
      chk("R5 full ripple", {co, s}, {1'b1, 32'h0});
      chk("R3 all prop", {{(DW+1-NG){1'b0}}, gp}, {{(DW+1-NG){1'b0}}, 4'hF});

      // R7: carry crosses into group 1, is absorbed by bit 8 (both zero)
      apply(32'h0000_00FF, 32'h0000_0001, 1'b0);
      chk("R7 absorb sum", {1'b0, s}, {1'b0, 32'h0000_0100});
      chk("R7 absorb cout", {{DW{1'b0}}, co}, '0);
      chk("R4 gen grp0", {{(DW+1-NG){1'b0}}, gg}, {{(DW+1-NG){1'b0}}, 4'h1});

      // R7: kill at the top bit stops carry_out
      apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
      chk("R7 top kill", {co, s}, {1'b0, 32'h8000_0000});

      // R4: generate at top group independent of carry_in
      apply(32'hFF00_0000, 32'h0100_0000, 1'b0);
      chk("R4 gen top", {co, s}, {1'b1, 32'h0});
      check_all();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule